// File: doc/BRIEF.md
# H-Bridge PWM Channel with Staged Mode Control

This block is a single motor-drive PWM channel. It holds a control byte, a duty value and a period value behind a small register port, runs its own timer counter, and drives a plus pin and a minus pin. Each pin has a data output and an output enable. The output-mode and alignment fields of the control byte are staged. A write lands in a shadow copy. The shadow is copied into the working copy at once when loading is safe. Otherwise the copy waits for the next counter wrap, so a mode change never cuts a PWM period short.

The timer counter is a three-state machine. **HALT** holds the count at zero while the period is zero. **UP** counts upward. **DOWN** counts downward and is used only for center alignment. The transitions are:
- HALT→UP when the period becomes nonzero.
- UP→UP with wrap to zero at period−1, for edge alignment. This is an overflow.
- UP→DOWN at period−1, for center alignment.
- DOWN→UP at zero. This is an overflow.
- Any state→HALT when the period is zero.

The PWM level from the compare stage passes through a short tap line that can delay it by 0 to 3 clocks. The pin map then turns it into pin levels.

Top module: `hbridge_pwm_chan`

## Requirements
- R1: After reset, every register reads zero, the channel is disabled, the minus pin is driven low (`minus_oe`=1, `minus_out`=0) and the plus pin is released (`plus_oe`=0, `plus_out`=0).
- R2: Address 0 reads the most recently written control byte with bits 3:2 forced to zero. Address 1 reads the duty, address 2 reads the period and address 3 reads zero. A control read shows the shadow value even while the working value differs.
- R3: Control bits 5:4 select alignment: 00 off, 01 left, 10 right, 11 center. With alignment off, the PWM level stays inactive.
- R4: With left alignment and a nonzero period P, the count runs 0..P−1 and the PWM is active while count < duty. After a write makes the period nonzero, the first count-0 clock is the second clock edge after the write edge.
- R5: With right alignment, the PWM is active while count ≥ P − duty.
- R6: With center alignment, the count runs 0..P−1 then P−1..0 (2P clocks), and the PWM is active while count < duty.
- R7: Control bits 7:6 select the pin map: 00 minus carries PWM and plus is released; 01 plus carries PWM and minus is released; 10 minus carries PWM and plus is held high; 11 plus carries PWM and minus is held high. A released pin has enable 0 and data 0.
- R8: A duty of zero gives a constant inactive PWM. A duty ≥ P (P nonzero) gives a constant active PWM across the wrap. A period of zero halts the counter and gives an inactive PWM.
- R9: While the period is nonzero and either the working alignment is not off or `peer_idle` is low, a written mode field takes effect only at the next overflow. Overflow is the wrap from P−1 to 0 in edge modes, or the bottom of the down count in center mode.
- R10: While the period is zero, or the working alignment is off and `peer_idle` is high, the shadow mode fields are copied to the working register on the next clock edge.
- R11: Control bits 1:0 hold a delay n that shifts both PWM edges later by exactly n clocks. The delay field is not staged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the timer count clock |
| rst | input | 1 | Synchronous active-high reset |
| peer_idle | input | 1 | High when every other channel sharing the timer is disabled |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 duty, 2 period |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| plus_out | output | 1 | Plus pin level |
| plus_oe | output | 1 | Plus pin drive enable |
| minus_out | output | 1 | Minus pin level |
| minus_oe | output | 1 | Minus pin drive enable |

## Verification
The assertions assume three things about the inputs:
- `peer_idle` is a level that is already settled when it is sampled.
- Duty and period change only while the counter is halted, so the count never sits above period−1 when a compare is made.
- The enum-coded mode fields only ever receive 2-bit values.

The stimulus keeps to these assumptions. It clears the period before every new setup and writes the duty before the period. It then restarts the counter from zero by writing a nonzero period, which makes every later pin level a pure function of the count phase.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int DLY_W = 2;

    typedef enum logic [1:0] {
        AL_OFF    = 2'b00,
        AL_LEFT   = 2'b01,
        AL_RIGHT  = 2'b10,
        AL_CENTER = 2'b11
    } align_e;

    typedef enum logic [1:0] {
        OM_HALF_MINUS = 2'b00,
        OM_HALF_PLUS  = 2'b01,
        OM_FULL       = 2'b10,
        OM_DUAL       = 2'b11
    } omode_e;

    typedef enum logic [1:0] {
        CS_HALT = 2'b00,
        CS_UP   = 2'b01,
        CS_DOWN = 2'b10
    } cstate_e;

    typedef struct packed {
        omode_e om;
        align_e al;
    } mode_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_DUTY   = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;

endpackage

// File: rtl/hbp_regs.sv
module hbp_regs
    import hbp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             peer_idle,
    input  logic             ovf,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CW-1:0]    wdata,
    output logic [CW-1:0]    rdata,
    output logic [CW-1:0]    duty,
    output logic [CW-1:0]    period,
    output mode_t            work,
    output logic [DLY_W-1:0] dly
);

    mode_t            shadow_q;
    mode_t            work_q;
    logic [DLY_W-1:0] dly_q;
    logic [CW-1:0]    duty_q;
    logic [CW-1:0]    period_q;
    logic             imm;

    // Safe to load at once: counter stopped, or nothing running on the timer
    assign imm = (period_q == '0) || (peer_idle && (work_q.al == AL_OFF));

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            dly_q    <= '0;
            duty_q   <= '0;
            period_q <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_CTRL: begin
                    shadow_q <= mode_t'(wdata[7:4]);
                    dly_q    <= wdata[DLY_W-1:0];
                end
                ADDR_DUTY:   duty_q   <= wdata;
                ADDR_PERIOD: period_q <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             work_q <= '0;
        else if (imm || ovf) work_q <= shadow_q;
    end

    always_comb begin
        case (addr)
            ADDR_CTRL:   rdata = CW'({shadow_q, 2'b00, dly_q});
            ADDR_DUTY:   rdata = duty_q;
            ADDR_PERIOD: rdata = period_q;
            default:     rdata = '0;
        endcase
    end

    assign duty   = duty_q;
    assign period = period_q;
    assign work   = work_q;
    assign dly    = dly_q;

    // R9: working mode is frozen unless a load point is reached
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!imm && !ovf) |=> $stable(work_q));

    // R10: at a load point the working copy takes the shadow value
    a_r10_load: assert property (@(posedge clk) disable iff (rst)
        (imm || ovf) |=> (work_q == $past(shadow_q)));

endmodule

// File: rtl/hbp_counter.sv
module hbp_counter
    import hbp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] period,
    input  logic          center,
    output logic [CW-1:0] cnt,
    output cstate_e       state,
    output logic          ovf
);

    cstate_e       state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] top;

    assign top = period - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        ovf     = 1'b0;
        unique case (state_q)
            CS_HALT: begin
                cnt_n   = '0;
                state_n = CS_UP;
            end
            CS_UP: begin
                if (cnt_q >= top) begin
                    if (center) begin
                        state_n = CS_DOWN;
                        cnt_n   = top;
                    end else begin
                        ovf   = 1'b1;
                        cnt_n = '0;
                    end
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            CS_DOWN: begin
                if (cnt_q == '0) begin
                    ovf     = 1'b1;
                    state_n = CS_UP;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: begin
                state_n = CS_HALT;
                cnt_n   = '0;
            end
        endcase
        if (period == '0) begin
            state_n = CS_HALT;
            cnt_n   = '0;
            ovf     = 1'b0;
        end
    end

    assign cnt   = cnt_q;
    assign state = state_q;

    // R8: a zero period stops the counter
    a_r8_halt: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |=> (state_q == CS_HALT));

    // R4: every overflow restarts the count at zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_q == '0));

    // R6: the down count is only ever used for center alignment
    a_r6_down: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_DOWN) |-> center);

endmodule

// File: rtl/hbp_wave.sv
module hbp_wave
    import hbp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    cnt,
    input  cstate_e          state,
    input  mode_t            work,
    input  logic [DLY_W-1:0] dly,
    input  logic [CW-1:0]    duty,
    input  logic [CW-1:0]    period,
    output logic             plus_out,
    output logic             plus_oe,
    output logic             minus_out,
    output logic             minus_oe
);

    localparam int MAXD = (1 << DLY_W) - 1;

    logic            raw;
    logic            pwm;
    logic [MAXD-1:0] pipe_q;
    logic [MAXD:0]   taps;

    always_comb begin
        if (work.al == AL_OFF || state == CS_HALT || duty == '0) begin
            raw = 1'b0;
        end else if (duty >= period) begin
            raw = 1'b1;
        end else begin
            unique case (work.al)
                AL_RIGHT: raw = (cnt >= (period - duty));
                default:  raw = (cnt < duty);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= raw;
            for (int i = 1; i < MAXD; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign taps = {pipe_q, raw};
    assign pwm  = taps[dly];

    always_comb begin
        unique case (work.om)
            OM_HALF_MINUS: {plus_out, plus_oe, minus_out, minus_oe} = {1'b0, 1'b0, pwm, 1'b1};
            OM_HALF_PLUS:  {plus_out, plus_oe, minus_out, minus_oe} = {pwm, 1'b1, 1'b0, 1'b0};
            OM_FULL:       {plus_out, plus_oe, minus_out, minus_oe} = {1'b1, 1'b1, pwm, 1'b1};
            OM_DUAL:       {plus_out, plus_oe, minus_out, minus_oe} = {pwm, 1'b1, 1'b1, 1'b1};
            default:       {plus_out, plus_oe, minus_out, minus_oe} = 4'b0000;
        endcase
    end

    // R3: an off channel never produces an active level
    a_r3_off: assert property (@(posedge clk) disable iff (rst)
        (work.al == AL_OFF) |-> !raw);

    // R8: zero duty is inactive in every alignment
    a_r8_zero: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !raw);

    // R11: one tick of delay repeats the previous compare result
    a_r11_dly1: assert property (@(posedge clk) disable iff (rst)
        (dly == DLY_W'(1)) |-> (pwm == $past(raw)));

endmodule

// File: rtl/hbridge_pwm_chan.sv
module hbridge_pwm_chan
    import hbp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          peer_idle,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output logic          plus_out,
    output logic          plus_oe,
    output logic          minus_out,
    output logic          minus_oe
);

    logic [CW-1:0]    duty, period, cnt;
    logic [DLY_W-1:0] dly;
    mode_t            work;
    cstate_e          state;
    logic             ovf;

    hbp_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .peer_idle(peer_idle), .ovf(ovf),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .duty(duty), .period(period), .work(work), .dly(dly)
    );

    hbp_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .period(period),
        .center(work.al == AL_CENTER),
        .cnt(cnt), .state(state), .ovf(ovf)
    );

    hbp_wave #(.CW(CW)) u_wave (
        .clk(clk), .rst(rst), .cnt(cnt), .state(state), .work(work),
        .dly(dly), .duty(duty), .period(period),
        .plus_out(plus_out), .plus_oe(plus_oe),
        .minus_out(minus_out), .minus_oe(minus_oe)
    );

endmodule

// File: tb/tb_hbridge_pwm_chan.sv
module tb_hbridge_pwm_chan;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       peer_idle = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       plus_out, plus_oe, minus_out, minus_oe;

    int errors = 0;
    int checks = 0;
    logic [3:0] expq[$];
    string      tagq[$];

    always #10 clk = ~clk;

    hbridge_pwm_chan dut (
        .clk(clk), .rst(rst), .peer_idle(peer_idle), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .plus_out(plus_out), .plus_oe(plus_oe),
        .minus_out(minus_out), .minus_oe(minus_oe)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit ref_pwm(int al, int p, int d, int k);
        int ph, c;
        if (al == 0 || d == 0) return 1'b0;
        if (d >= p) return 1'b1;
        case (al)
            1: return (k % p) < d;
            2: return (k % p) >= (p - d);
            default: begin
                ph = k % (2 * p);
                c  = (ph < p) ? ph : (2 * p - 1 - ph);
                return c < d;
            end
        endcase
    endfunction

    // {plus_out, plus_oe, minus_out, minus_oe}
    function automatic logic [3:0] ref_pins(int om, bit p);
        case (om)
            0: return {1'b0, 1'b0, p, 1'b1};
            1: return {p, 1'b1, 1'b0, 1'b0};
            2: return {1'b1, 1'b1, p, 1'b1};
            default: return {p, 1'b1, 1'b1, 1'b1};
        endcase
    endfunction

    function automatic logic [3:0] pins_now();
        return {plus_out, plus_oe, minus_out, minus_oe};
    endfunction

    // Monitor: samples 5 ns after each rising edge, pops one expected item
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (expq.size() > 0) begin
                logic [3:0] e;
                string      t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(t, {4'h0, pins_now()}, {4'h0, e});
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Clears the period, sets control and duty, then starts the counter.
    // Returns one negedge after the period write; window k=0 follows the next edge.
    task automatic setup(int om, int al, int dl, int p, int d);
        wr(2'd2, 8'd0);
        wr(2'd0, {om[1:0], al[1:0], 2'b00, dl[1:0]});
        wr(2'd1, d[7:0]);
        repeat (4) @(negedge clk);
        wr(2'd2, p[7:0]);
    endtask

    task automatic run(string tag, int om, int al, int dl, int p, int d, int n);
        setup(om, al, dl, p, d);
        for (int k = 0; k < n; k++) begin
            expq.push_back(ref_pins(om, (k < dl) ? 1'b0 : ref_pwm(al, p, d, k - dl)));
            tagq.push_back(tag);
        end
        wait (expq.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        addr = 2'd0; #1 chk("R1 ctrl", rdata, 8'h00);
        addr = 2'd1; #1 chk("R1 duty", rdata, 8'h00);
        addr = 2'd2; #1 chk("R1 period", rdata, 8'h00);
        chk("R1 pins", {4'h0, pins_now()}, 8'h01);

        // R2 readback, reserved bits zero
        wr(2'd0, 8'hFF);
        addr = 2'd0; #1 chk("R2 ctrl rsv", rdata, 8'hF3);
        wr(2'd1, 8'hA5);
        #1 chk("R2 duty", rdata, 8'hA5);
        addr = 2'd3; #1 chk("R2 addr3", rdata, 8'h00);
        // R8 zero period inactive, R7 dual map: plus=pwm=0, minus held high
        repeat (2) @(negedge clk);
        #1 chk("R8 R7 period0", {4'h0, pins_now()}, 8'h07);

        run("R4 left", 0, 1, 0, 8, 3, 24);
        run("R5 right", 1, 2, 0, 6, 2, 18);
        run("R6 center", 2, 3, 0, 5, 2, 30);
        run("R11 R7 dly3 dual", 3, 1, 3, 7, 4, 21);
        run("R11 R6 dly2 center", 0, 3, 2, 4, 1, 16);
        run("R8 duty0", 2, 1, 0, 6, 0, 12);
        run("R8 duty over", 0, 2, 0, 5, 9, 15);
        run("R8 duty equal", 1, 1, 0, 5, 5, 10);
        run("R3 off", 2, 0, 0, 6, 3, 12);

        // R9: mid-period mode change waits for the wrap at k=8
        peer_idle = 1'b0;
        setup(0, 1, 0, 8, 2);
        for (int k = 0; k < 24; k++) begin
            expq.push_back((k < 8) ? ref_pins(0, ref_pwm(1, 8, 2, k))
                                   : ref_pins(1, ref_pwm(2, 8, 2, k)));
            tagq.push_back("R9 staged");
        end
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h60);
        addr = 2'd0; #1 chk("R2 shadow read", rdata, 8'h60);
        wait (expq.size() == 0);
        @(negedge clk);

        // R9: channel off but peers active, still waits for the wrap
        setup(1, 0, 0, 8, 7);
        for (int k = 0; k < 16; k++) begin
            expq.push_back(ref_pins(1, (k < 8) ? 1'b0 : ref_pwm(1, 8, 7, k)));
            tagq.push_back("R9 peers busy");
        end
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h50);
        wait (expq.size() == 0);
        @(negedge clk);

        // R10: channel off and peers idle, load on the next edge (k=5)
        peer_idle = 1'b1;
        setup(1, 0, 0, 8, 7);
        for (int k = 0; k < 16; k++) begin
            expq.push_back(ref_pins(1, (k < 5) ? 1'b0 : ref_pwm(1, 8, 7, k)));
            tagq.push_back("R10 immediate");
        end
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h50);
        wait (expq.size() == 0);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule